// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial bus (SCL clock, SDA open-drain data) in front of a 1024 x 8 byte memory. It samples both bus lines on the system clock through a synchronizer, recognises start and stop conditions, and answers only when the address byte carries the fixed type code and a select bit equal to its `dev_sel_i` strap. The same address byte also supplies the two top memory address bits and the read/write direction.

A write transfer loads a word address and then up to a page of data bytes into a holding buffer. All buffered bytes go into the array together when the stop condition arrives. A self-timed busy window follows, standing in for the program cycle. During that window the block ignores the bus completely. Reads return bytes from an auto-incrementing address counter. They continue for as long as the master acknowledges each byte.

Top module: `eep2w_slave`

## Requirements
- R1: After reset `sda_oe_o` is 0, the block waits for a start, and every array location reads 8'hFF.
- R2: The address byte after a start is acknowledged (`sda_oe_o`=1 through the ninth clock) only when bits [7:4] equal 4'b1010 and bit [3] equals `dev_sel_i`. Any other byte gets no acknowledge, and the block ignores the bus until the next start.
- R3: The 10-bit memory address is formed from address-byte bits [2:1] as bits [9:8] and the following word address byte as bits [7:0].
- R4: Address-byte bit [0] selects the direction: 1 is a read and 0 is a write.
- R5: Each word address byte and data byte of a write transfer is acknowledged. A stop after at least one data byte commits the data, and the committed data reads back afterwards.
- R6: Within one write transfer only address bits [3:0] advance after each data byte, wrapping inside the 16-byte page while bits [9:4] stay fixed. A later byte for the same slot replaces the earlier one. All buffered bytes are committed at the stop.
- R7: For BUSY_CYCLES clocks after a committing stop, `sda_oe_o` stays 0 and the block does not acknowledge its own address. Afterwards it responds again.
- R8: A write transfer ended by a start before any stop, or stopped with no data byte, writes nothing and starts no busy window.
- R9: Read data is sent MSB first starting at the current address. The full 10-bit address increments after each byte, wrapping from 1023 to 0, and reading continues while the master acknowledges.
- R10: When the master does not acknowledge a read byte, the block releases SDA and waits for the next start.
- R11: A read with no new word address starts at the address following the last byte accessed. The top two bits come from the address byte.
- R12: `sda_oe_o` changes only after a detected falling edge of SCL, while SCL is low.
- R13: A start in the middle of a transfer abandons it and restarts address-byte reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| dev_sel_i | input | 1 | Strap compared with address-byte bit 3 |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench overrides BUSY_CYCLES with 2000 so that both the silent window and its end fall inside a short run. An address poll issued right after a stop lands inside the window, and a later one lands after it. The 10-bit address, the 16-byte page and the two-stage synchronizer keep their default values. This lets a page write overrun its page boundary, and lets a sequential read run from one page into the next and across the 1023-to-0 wrap.

// File: rtl/eep2w_pkg.sv
package eep2w_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } eep_state_e;

  localparam logic [3:0] BYTE_BITS = 4'd8;
endpackage

// File: rtl/eep2w_sync.sv
module eep2w_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = ~scl_q & scl_s;
  assign scl_fall_o = scl_q & ~scl_s;
  // data edges while the clock stays high
  assign start_o    = scl_q & scl_s & sda_q & ~sda_o;
  assign stop_o     = scl_q & scl_s & ~sda_q & sda_o;
endmodule

// File: rtl/eep2w_busy_timer.sv
module eep2w_busy_timer #(
  parameter int unsigned CYCLES = 1000,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eep2w_page_buf.sv
module eep2w_page_buf #(
  parameter int PAGE_BYTES = 16,
  localparam int SLOT_W = $clog2(PAGE_BYTES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [SLOT_W-1:0]           slot_i,
  input  logic [7:0]                  data_i,
  input  logic                        clr_i,
  output logic [PAGE_BYTES-1:0][7:0]  data_o,
  output logic [PAGE_BYTES-1:0]       valid_o,
  output logic                        any_o
);
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
        data_o[g]  <= '0;
      end else if (clr_i) begin
        valid_o[g] <= 1'b0;
      end else if (wr_i && slot_i == SLOT_W'(g)) begin
        valid_o[g] <= 1'b1;
        data_o[g]  <= data_i;
      end
    end
  end

  assign any_o = |valid_o;
endmodule

// File: rtl/eep2w_mem.sv
module eep2w_mem #(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 16,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int SLOT_W = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_W - SLOT_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       commit_i,
  input  logic [PAGE_W-1:0]          page_i,
  input  logic [PAGE_BYTES-1:0][7:0] pdata_i,
  input  logic [PAGE_BYTES-1:0]      pvalid_i,
  input  logic [ADDR_W-1:0]          raddr_i,
  output logic [7:0]                 rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (commit_i) begin
      for (int s = 0; s < PAGE_BYTES; s++) begin
        if (pvalid_i[s]) mem_q[{page_i, SLOT_W'(s)}] <= pdata_i[s];
      end
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eep2w_slave.sv
module eep2w_slave
  import eep2w_pkg::*;
#(
  parameter int          ADDR_W      = 10,
  parameter int          PAGE_BYTES  = 16,
  parameter int unsigned BUSY_CYCLES = 500000,
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  DEV_TYPE    = 4'b1010
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic dev_sel_i,
  output logic sda_oe_o
);
  localparam int HI_W   = ADDR_W - 8;
  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - SLOT_W;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, commit, byte_done, dev_match;
  logic pb_wr, pb_clr, pb_any;
  logic [PAGE_BYTES-1:0][7:0] pb_data;
  logic [PAGE_BYTES-1:0]      pb_valid;
  logic [7:0] rdata;

  eep_state_e        state_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q, tx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rw_q, mack_q, oe_q;

  eep2w_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  eep2w_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (commit),
    .busy_o (busy)
  );

  eep2w_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_pbuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (pb_wr),
    .slot_i  (addr_q[SLOT_W-1:0]),
    .data_i  (sh_q),
    .clr_i   (pb_clr),
    .data_o  (pb_data),
    .valid_o (pb_valid),
    .any_o   (pb_any)
  );

  eep2w_mem #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .page_i   (addr_q[ADDR_W-1:SLOT_W]),
    .pdata_i  (pb_data),
    .pvalid_i (pb_valid),
    .raddr_i  (addr_q),
    .rdata_o  (rdata)
  );

  assign byte_done = scl_fall && (cnt_q == BYTE_BITS);
  assign dev_match = (sh_q[7:4] == DEV_TYPE) && (sh_q[3] == dev_sel_i);
  assign pb_wr     = !busy && (state_q == ST_WDATA) && byte_done;
  assign pb_clr    = start_det || stop_det;
  assign commit    = !busy && stop_det && pb_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      addr_q  <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (busy) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else if (start_det) begin
      state_q <= ST_DEV;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise) begin
            sh_q  <= {sh_q[6:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
          end
          if (byte_done) begin
            cnt_q <= '0;
            if (state_q == ST_DEV) begin
              if (dev_match) begin
                addr_q[ADDR_W-1:8] <= sh_q[HI_W:1];
                rw_q    <= sh_q[0];
                oe_q    <= 1'b1;
                state_q <= ST_DEV_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (state_q == ST_WADDR) begin
              addr_q[7:0] <= sh_q;
              oe_q        <= 1'b1;
              state_q     <= ST_WADDR_ACK;
            end else begin
              addr_q[SLOT_W-1:0] <= addr_q[SLOT_W-1:0] + 1'b1;
              oe_q               <= 1'b1;
              state_q            <= ST_WDATA_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q    <= rdata;
              oe_q    <= ~rdata[7];
              state_q <= ST_RDATA;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WADDR;
            end
          end
        end
        ST_WADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            oe_q    <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) cnt_q <= cnt_q + 1'b1;
          if (scl_fall) begin
            if (cnt_q == BYTE_BITS) begin
              oe_q    <= 1'b0;
              addr_q  <= addr_q + 1'b1;
              state_q <= ST_RACK;
            end else begin
              tx_q <= {tx_q[6:0], 1'b0};
              oe_q <= ~tx_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              tx_q    <= rdata;
              oe_q    <= ~rdata[7];
              cnt_q   <= '0;
              state_q <= ST_RDATA;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/eep2w_chk.sv
module eep2w_chk
  import eep2w_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SLOT_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_fall_i,
  input logic              start_i,
  input logic              stop_i,
  input logic              busy_i,
  input logic              sda_oe_i,
  input eep_state_e        state_i,
  input logic [ADDR_W-1:0] addr_i
);
  // R12
  oe_edge_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> $past(scl_fall_i));

  // R7
  busy_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !sda_oe_i);

  // R7
  busy_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(stop_i));

  // R13
  start_restarts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i) |=> state_i == ST_DEV);

  // R6
  page_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WDATA_ACK && $past(state_i) == ST_WDATA)
      |-> addr_i[ADDR_W-1:SLOT_W] == $past(addr_i[ADDR_W-1:SLOT_W]));
endmodule

bind eep2w_slave eep2w_chk #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_fall_i (scl_fall),
  .start_i    (start_det),
  .stop_i     (stop_det),
  .busy_i     (busy),
  .sda_oe_i   (sda_oe_o),
  .state_i    (state_q),
  .addr_i     (addr_q)
);

// File: tb/sim_eep2w_slave.sv
module sim_eep2w_slave;
  localparam int BUSY = 2000;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, dev_sel = 1'b1;
  logic sda_oe;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  eep2w_slave #(.BUSY_CYCLES(BUSY)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .dev_sel_i (dev_sel),
    .sda_oe_o  (sda_oe)
  );

  int checks = 0, errors = 0, r12_bad = 0;
  logic [7:0] ref_mem [1024];
  logic oe_prev = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R12 monitor: enable must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== oe_prev) && scl_m) r12_bad++;
    oe_prev = sda_oe;
  end

  function automatic logic [7:0] dev_b(input int a, input bit rw, input bit sel = 1'b1);
    return {4'b1010, sel, 2'(a >> 8), rw};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    ack = (sda_line == 1'b0);
    wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(Q); scl_m = 1'b1; wq(Q);
      d = {d[6:0], sda_line};
      wq(Q); scl_m = 1'b0; wq(Q);
    end
    send_bit(nack);
  endtask

  task automatic write_seq(input int addr, input int n, input int base, input string req);
    bit ack;
    bus_start();
    send_byte(dev_b(addr, 1'b0), ack); chk(ack, "R2", ack, 1);
    send_byte(8'(addr), ack);          chk(ack, req, ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(8'(base + i), ack);    chk(ack, req, ack, 1);
      ref_mem[(addr & ~15) | ((addr + i) & 15)] = 8'(base + i);
    end
    bus_stop();
  endtask

  task automatic read_seq(input int addr, input int n, input string req);
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte(dev_b(addr, 1'b0), ack); chk(ack, "R4", ack, 1);
    send_byte(8'(addr), ack);          chk(ack, "R3", ack, 1);
    bus_start();
    send_byte(dev_b(addr, 1'b1), ack); chk(ack, "R4", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, d);
      chk(d == ref_mem[(addr + i) % 1024], req, d, ref_mem[(addr + i) % 1024]);
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    read_seq(12'h123, 2, "R1");
  endtask

  task automatic t_byte_write();
    write_seq(12'h2A5, 1, 8'h3C, "R5");
    wq(BUSY + 200);
    read_seq(12'h2A5, 1, "R5");
    read_seq(12'h0A5, 1, "R3");
  endtask

  task automatic t_mismatch();
    bit ack;
    bus_start();
    send_byte(8'hB2, ack); chk(!ack, "R2", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R2", ack, 0);
    bus_stop();
    bus_start();
    send_byte(dev_b(0, 1'b0, 1'b0), ack); chk(!ack, "R2", ack, 0);
    bus_stop();
    dev_sel = 1'b0;
    bus_start();
    send_byte(dev_b(0, 1'b0, 1'b0), ack); chk(ack, "R2", ack, 1);
    bus_stop();
    dev_sel = 1'b1;
  endtask

  task automatic t_busy();
    bit ack;
    write_seq(12'h010, 1, 8'h55, "R5");
    bus_start();
    send_byte(dev_b(12'h010, 1'b0), ack); chk(!ack, "R7", ack, 0);
    bus_stop();
    bus_start();
    send_byte(dev_b(12'h010, 1'b1), ack); chk(!ack, "R7", ack, 0);
    bus_stop();
    wq(BUSY);
    bus_start();
    send_byte(dev_b(12'h010, 1'b0), ack); chk(ack, "R7", ack, 1);
    bus_stop();
    read_seq(12'h010, 1, "R7");
  endtask

  task automatic t_page();
    // 18 bytes from slot 8: wraps to slot 0, last two replace slots 8 and 9
    write_seq(12'h1F8, 18, 8'h80, "R6");
    wq(BUSY + 200);
    read_seq(12'h1F0, 17, "R6");
    read_seq(12'h1FE, 4, "R9");
  endtask

  task automatic t_read_wrap();
    write_seq(12'h3FF, 1, 8'hA7, "R5");
    wq(BUSY + 200);
    read_seq(12'h3FF, 3, "R9");
  endtask

  task automatic t_current();
    bit ack;
    logic [7:0] d;
    read_seq(12'h1F3, 1, "R9");
    chk(sda_oe == 1'b0, "R10", sda_oe, 0);
    bus_start();
    send_byte(dev_b(12'h100, 1'b1), ack); chk(ack, "R11", ack, 1);
    recv_byte(1'b0, d); chk(d == ref_mem[12'h1F4], "R11", d, ref_mem[12'h1F4]);
    recv_byte(1'b1, d); chk(d == ref_mem[12'h1F5], "R11", d, ref_mem[12'h1F5]);
    wq(Q);
    chk(sda_oe == 1'b0, "R10", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_abort();
    bit ack;
    bus_start();
    send_byte(dev_b(12'h050, 1'b0), ack); chk(ack, "R2", ack, 1);
    send_byte(8'h50, ack);                chk(ack, "R3", ack, 1);
    send_byte(8'h99, ack);                chk(ack, "R5", ack, 1);
    bus_start();
    send_byte(dev_b(12'h050, 1'b0), ack); chk(ack, "R8", ack, 1);
    bus_stop();
    bus_start();
    send_byte(dev_b(12'h050, 1'b0), ack); chk(ack, "R8", ack, 1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_byte(dev_b(12'h050, 1'b0), ack); chk(ack, "R13", ack, 1);
    bus_stop();
    read_seq(12'h050, 1, "R8");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) ref_mem[i] = 8'hFF;
    wq(5);
    rst_n = 1'b1;
    wq(10);
    t_reset();
    t_byte_write();
    t_mismatch();
    t_busy();
    t_page();
    t_read_wrap();
    t_current();
    t_abort();
    chk(r12_bad == 0, "R12", r12_bad, 0);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule